// File: doc/BRIEF.md
# Memory-Mapped Master Transaction Issuer

This block is the master side of a memory-mapped bus. Commands are queued through a push port into a small internal command store. Each command holds a direction, an address-mode flag, an address, byte enables, a burst length, a pre-issue delay and a post-command idle gap. Write data words are queued separately through a second push port. The engine takes one command at a time and waits out its pre-issue delay. It then sends the command on the bus as one transfer per data word and respects the slave's wait-request. Once the final word is accepted, it holds the bus quiet for the command's idle gap before it takes the next command.

Burst addresses either increment by one word (4 bytes) per transfer or wrap inside an aligned line window. Every command carries a sequential transaction number, and a one-cycle strobe marks the first cycle in which a command appears on the bus. A build-time option replaces the wait-request input with fixed read and write wait counts. This serves slaves that have no stall signal. Capture of read data is handled by a separate tracker.

Top module: `miss_issuer`

## Requirements
- R1: While synchronous reset is high and in the first cycle after it is released, bus_read, bus_write and issued are low and txn_id is 0.
- R2: When a command is pushed into an idle engine with an empty queue, the bus stays quiet for exactly cmd_init + 1 cycles, counted from the cycle after the push edge, before the command is presented.
- R3: When command B is queued behind command A, the bus is quiet for exactly idle(A) + 1 + init(B) cycles between the acceptance of A's last word and B's first presentation.
- R4: While a transfer is presented and bus_waitreq is high, the direction, address, byte enables, burst count and (for writes) write data hold, and the transfer stays on the bus. It advances only on an edge where bus_waitreq is low.
- R5: A command with burst field N (3 bits) makes exactly max(N,1) accepted transfers. bus_burstcount shows max(N,1) on each of them, exactly one of bus_read or bus_write is high, and no transfer follows the last one.
- R6: With cmd_wrap set, each next address adds 4 bytes but keeps the bits above the aligned LINE_WORDS*4-byte window (16 bytes by default), so 0x308 is followed by 0x30C, 0x300 and 0x304. With cmd_wrap clear the address adds 4 plainly.
- R7: Write transfers carry the queued data words in push order, one word consumed per accepted write transfer. bus_write is not raised while no write word is queued.
- R8: issued is high for exactly one cycle per command, in the first cycle the command is presented, even if that transfer is stalled.
- R9: txn_id is constant across all transfers of a command and increases by one (modulo 16) from each command to the next, starting at 0 after reset.
- R10: With USE_WAITREQ = 0, bus_waitreq is ignored. Each write transfer is presented for WR_WAIT + 1 cycles and each read transfer for RD_WAIT + 1 cycles (4 and 3 by default).
- R11: A reset raised in the middle of a command drops it at once: read and write go low on the next cycle, and the next command issued carries txn_id 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Enqueue the command on the cmd_* fields |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_wrap | input | 1 | 1 = line-wrapping burst addresses |
| cmd_addr | input | 16 | Byte address of the first word |
| cmd_be | input | 4 | Byte enables for every transfer of the command |
| cmd_burst | input | 3 | Burst length in words, 0 treated as 1 |
| cmd_init | input | 4 | Cycles to wait before presenting the command |
| cmd_idle | input | 4 | Quiet cycles after the command's last transfer |
| cmd_full | output | 1 | Command queue full; a push is dropped |
| wd_push | input | 1 | Enqueue wd_data as a write word |
| wd_data | input | 32 | Write data word |
| wd_full | output | 1 | Write-word queue full; a push is dropped |
| bus_read | output | 1 | Read transfer presented |
| bus_write | output | 1 | Write transfer presented |
| bus_addr | output | 16 | Transfer byte address |
| bus_be | output | 4 | Transfer byte enables |
| bus_burstcount | output | 3 | Effective burst length of the current command |
| bus_wdata | output | 32 | Write data of the current transfer |
| bus_waitreq | input | 1 | Slave stall; ignored when USE_WAITREQ = 0 |
| issued | output | 1 | One-cycle strobe at a command's first presentation |
| txn_id | output | 4 | Transaction number of the current command |

## Verification
A miscounted phase counter shows directly as a wrong number of quiet bus cycles before or after a command. The bench sees that within the same command, since it counts those cycles exactly. A wrong beat counter or address register gives an extra, missing or misplaced transfer, which is detected on the cycle that transfer appears or on the cycle after the expected last one. A stale first-presentation flag or transaction counter corrupts issued or txn_id on the very next command's first cycle. A write-store pointer that slips delivers a wrong data word on the next accepted write transfer.

// File: rtl/miss_pkg.sv
`timescale 1ns/1ps
package miss_pkg;

    parameter int ADDR_W = 16;
    parameter int SYM_W  = 8;
    parameter int NSYM   = 4;
    parameter int BC_W   = 3;
    parameter int DLY_W  = 4;
    parameter int TID_W  = 4;
    localparam int DATA_W = SYM_W * NSYM;

    typedef struct packed {
        logic              wr;
        logic              wrap;
        logic [ADDR_W-1:0] addr;
        logic [NSYM-1:0]   be;
        logic [BC_W-1:0]   burst;
        logic [DLY_W-1:0]  init_dly;
        logic [DLY_W-1:0]  idle_dly;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_XFER = 2'd2,
        ST_GAP  = 2'd3
    } state_e;

    // Burst field of zero behaves as a single word.
    function automatic logic [BC_W-1:0] eff_burst(input logic [BC_W-1:0] b);
        return (b == '0) ? BC_W'(1) : b;
    endfunction

    // Next word address; in wrap mode only the bits under wmask move.
    function automatic logic [ADDR_W-1:0] next_addr(
        input logic [ADDR_W-1:0] a,
        input logic              wrap,
        input logic [ADDR_W-1:0] wmask
    );
        logic [ADDR_W-1:0] inc;
        inc = a + ADDR_W'(NSYM);
        return wrap ? ((a & ~wmask) | (inc & wmask)) : inc;
    endfunction

endpackage

// File: rtl/miss_fifo.sv
`timescale 1ns/1ps
module miss_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/miss_down_cnt.sv
`timescale 1ns/1ps
module miss_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] val;

    assign zero = (val == '0);

    always_ff @(posedge clk) begin
        if (rst)              val <= '0;
        else if (load)        val <= load_val;
        else if (dec && !zero) val <= val - 1'b1;
    end
endmodule

// File: rtl/miss_issuer.sv
`timescale 1ns/1ps
module miss_issuer
    import miss_pkg::*;
#(
    parameter int CMD_DEPTH   = 4,
    parameter int WD_DEPTH    = 8,
    parameter int LINE_WORDS  = 4,
    parameter bit USE_WAITREQ = 1'b1,
    parameter int RD_WAIT     = 2,
    parameter int WR_WAIT     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_push,
    input  logic              cmd_write,
    input  logic              cmd_wrap,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NSYM-1:0]   cmd_be,
    input  logic [BC_W-1:0]   cmd_burst,
    input  logic [DLY_W-1:0]  cmd_init,
    input  logic [DLY_W-1:0]  cmd_idle,
    output logic              cmd_full,
    input  logic              wd_push,
    input  logic [DATA_W-1:0] wd_data,
    output logic              wd_full,
    output logic              bus_read,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [NSYM-1:0]   bus_be,
    output logic [BC_W-1:0]   bus_burstcount,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_waitreq,
    output logic              issued,
    output logic [TID_W-1:0]  txn_id
);
    localparam int CMD_W = $bits(cmd_t);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_WORDS * NSYM - 1);

    cmd_t              in_cmd, head, cur;
    state_e            state, state_nx;
    logic              cmd_empty, wd_empty;
    logic              cmd_pop, present, stall, accept, last;
    logic [ADDR_W-1:0] addr_q;
    logic [BC_W-1:0]   beats_left;
    logic              first_q;
    logic [TID_W-1:0]  tid_q;
    logic              ph_load, ph_dec, ph_zero;
    logic [DLY_W-1:0]  ph_val;

    assign in_cmd = '{wr: cmd_write, wrap: cmd_wrap, addr: cmd_addr, be: cmd_be,
                      burst: cmd_burst, init_dly: cmd_init, idle_dly: cmd_idle};

    miss_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk(clk), .rst(rst), .push(cmd_push), .din(in_cmd), .pop(cmd_pop),
        .dout(head), .full(cmd_full), .empty(cmd_empty)
    );

    miss_fifo #(.W(DATA_W), .DEPTH(WD_DEPTH)) u_wdq (
        .clk(clk), .rst(rst), .push(wd_push), .din(wd_data), .pop(accept && cur.wr),
        .dout(bus_wdata), .full(wd_full), .empty(wd_empty)
    );

    // Handshake for the current transfer.
    assign cmd_pop = (state == ST_IDLE) && !cmd_empty;
    assign present = (state == ST_XFER) && (!cur.wr || !wd_empty);
    assign accept  = present && !stall;
    assign last    = accept && (beats_left == BC_W'(1));

    generate
        if (USE_WAITREQ) begin : g_ext_wait
            assign stall = bus_waitreq;
        end else begin : g_fixed_wait
            localparam int WMAX = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
            localparam int WW   = $clog2(WMAX + 1) + 1;
            logic [WW-1:0] wcnt, wlim;
            assign wlim  = cur.wr ? WW'(WR_WAIT) : WW'(RD_WAIT);
            assign stall = (wcnt < wlim);
            always_ff @(posedge clk) begin
                if (rst || cmd_pop || accept) wcnt <= '0;
                else if (present && stall)    wcnt <= wcnt + 1'b1;
            end
        end
    endgenerate

    // Shared counter for the pre-issue delay and the post-command gap.
    assign ph_load = (cmd_pop && (head.init_dly != '0)) || (last && (cur.idle_dly != '0));
    assign ph_val  = cmd_pop ? (head.init_dly - 1'b1) : (cur.idle_dly - 1'b1);
    assign ph_dec  = (state == ST_INIT) || (state == ST_GAP);

    miss_down_cnt #(.W(DLY_W)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val),
        .dec(ph_dec), .zero(ph_zero)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (cmd_pop) state_nx = (head.init_dly == '0) ? ST_XFER : ST_INIT;
            ST_INIT: if (ph_zero) state_nx = ST_XFER;
            ST_XFER: if (last)    state_nx = (cur.idle_dly == '0) ? ST_IDLE : ST_GAP;
            ST_GAP:  if (ph_zero) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            addr_q     <= '0;
            beats_left <= '0;
            first_q    <= 1'b0;
            tid_q      <= '0;
        end else begin
            state <= state_nx;
            if (cmd_pop) begin
                cur        <= head;
                addr_q     <= head.addr;
                beats_left <= eff_burst(head.burst);
                first_q    <= 1'b1;
            end else begin
                if (present) first_q <= 1'b0;
                if (accept) begin
                    addr_q     <= next_addr(addr_q, cur.wrap, LINE_MASK);
                    beats_left <= beats_left - 1'b1;
                end
                if (last) tid_q <= tid_q + 1'b1;
            end
        end
    end

    assign bus_read       = present && !cur.wr;
    assign bus_write      = present && cur.wr;
    assign bus_addr       = addr_q;
    assign bus_be         = cur.be;
    assign bus_burstcount = eff_burst(cur.burst);
    assign issued         = present && first_q;
    assign txn_id         = tid_q;
endmodule

// File: rtl/miss_issuer_chk.sv
`timescale 1ns/1ps
module miss_issuer_chk
    import miss_pkg::*;
#(
    parameter bit USE_WAITREQ = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_read,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSYM-1:0]   bus_be,
    input logic [BC_W-1:0]   bus_burstcount,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_waitreq,
    input logic              issued,
    input logic [TID_W-1:0]  txn_id
);
    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (USE_WAITREQ && (bus_read || bus_write) && bus_waitreq) |=>
        (bus_read == $past(bus_read) && bus_write == $past(bus_write) &&
         $stable(bus_addr) && $stable(bus_be) && $stable(bus_burstcount) &&
         (!bus_write || $stable(bus_wdata))));

    // R5
    one_dir_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_read && bus_write));

    // R5
    burst_range_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_read || bus_write) |-> (bus_burstcount != '0));

    // R8
    issued_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        issued |=> !issued);

    // R8
    issued_active_chk: assert property (@(posedge clk) disable iff (rst)
        issued |-> (bus_read || bus_write));

    // R9
    tid_step_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_id != $past(txn_id)) |-> (txn_id == TID_W'($past(txn_id) + 1'b1)));

    // R11
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_read && !bus_write && txn_id == '0));
endmodule

bind miss_issuer miss_issuer_chk #(.USE_WAITREQ(USE_WAITREQ)) u_chk (
    .clk(clk), .rst(rst), .bus_read(bus_read), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_burstcount(bus_burstcount),
    .bus_wdata(bus_wdata), .bus_waitreq(bus_waitreq), .issued(issued),
    .txn_id(txn_id)
);

// File: tb/sim_miss_issuer.sv
`timescale 1ns/1ps
module sim_miss_issuer;
    import miss_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        cmd_push = 0, cmd_push1 = 0, wd_push = 0, wd_push1 = 0;
    logic        cmd_write = 0, cmd_wrap = 0;
    logic [15:0] cmd_addr = '0;
    logic [3:0]  cmd_be = 4'hF;
    logic [2:0]  cmd_burst = '0;
    logic [3:0]  cmd_init = '0, cmd_idle = '0;
    logic [31:0] wd_data = '0;
    logic        wreq = 1'b0;

    logic        o_cfull, o_wfull, o_rd, o_wr, o_iss;
    logic [15:0] o_addr;
    logic [3:0]  o_be, o_tid;
    logic [2:0]  o_bc;
    logic [31:0] o_wdata;
    logic        p_cfull, p_wfull, p_rd, p_wr, p_iss;
    logic [15:0] p_addr;
    logic [3:0]  p_be, p_tid;
    logic [2:0]  p_bc;
    logic [31:0] p_wdata;

    miss_issuer u0 (
        .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_write(cmd_write), .cmd_wrap(cmd_wrap),
        .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_burst(cmd_burst), .cmd_init(cmd_init),
        .cmd_idle(cmd_idle), .cmd_full(o_cfull), .wd_push(wd_push), .wd_data(wd_data),
        .wd_full(o_wfull), .bus_read(o_rd), .bus_write(o_wr), .bus_addr(o_addr), .bus_be(o_be),
        .bus_burstcount(o_bc), .bus_wdata(o_wdata), .bus_waitreq(wreq), .issued(o_iss),
        .txn_id(o_tid)
    );

    miss_issuer #(.USE_WAITREQ(1'b0)) u1 (
        .clk(clk), .rst(rst), .cmd_push(cmd_push1), .cmd_write(cmd_write), .cmd_wrap(cmd_wrap),
        .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_burst(cmd_burst), .cmd_init(cmd_init),
        .cmd_idle(cmd_idle), .cmd_full(p_cfull), .wd_push(wd_push1), .wd_data(wd_data),
        .wd_full(p_wfull), .bus_read(p_rd), .bus_write(p_wr), .bus_addr(p_addr), .bus_be(p_be),
        .bus_burstcount(p_bc), .bus_wdata(p_wdata), .bus_waitreq(wreq), .issued(p_iss),
        .txn_id(p_tid)
    );

    typedef struct packed {
        logic        wr;
        logic        wrap;
        logic [15:0] addr;
        logic [2:0]  burst;
        logic [3:0]  init;
        logic [3:0]  idle;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0100, 3'd1, 4'd2, 4'd0, 2'd0},
        '{1'b1, 1'b0, 16'h0200, 3'd4, 4'd0, 4'd1, 2'd1},
        '{1'b0, 1'b1, 16'h0308, 3'd4, 4'd1, 4'd0, 2'd2},
        '{1'b1, 1'b1, 16'h040C, 3'd3, 4'd3, 4'd2, 2'd0},
        '{1'b0, 1'b0, 16'h050C, 3'd0, 4'd0, 4'd0, 2'd0},
        '{1'b1, 1'b0, 16'h0600, 3'd7, 4'd2, 4'd0, 2'd1},
        '{1'b0, 1'b1, 16'h0504, 3'd7, 4'd0, 4'd3, 2'd0}
    };

    int n_chk = 0, n_bad = 0;
    int tid_exp = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_next(input logic [15:0] a, input logic wrap);
        logic [15:0] inc;
        inc = a + 16'd4;
        return wrap ? {a[15:4], inc[3:0]} : inc;
    endfunction

    function automatic logic [31:0] data_of(input int v, input int k);
        return 32'hD000_0000 | 32'(v << 8) | 32'(k);
    endfunction

    task automatic push_words(input int v, input int n, input bit to1);
        for (int k = 0; k < n; k++) begin
            wd_data = data_of(v, k);
            if (to1) wd_push1 = 1'b1; else wd_push = 1'b1;
            @(negedge clk);
        end
        wd_push = 1'b0;
        wd_push1 = 1'b0;
    endtask

    task automatic push_cmd(input vec_t c, input bit to1);
        cmd_write = c.wr; cmd_wrap = c.wrap; cmd_addr = c.addr; cmd_burst = c.burst;
        cmd_init = c.init; cmd_idle = c.idle;
        if (to1) cmd_push1 = 1'b1; else cmd_push = 1'b1;
        @(negedge clk);
        cmd_push = 1'b0;
        cmd_push1 = 1'b0;
    endtask

    task automatic count_quiet(output int q);
        q = 0;
        while (!(o_rd || o_wr) && q < 60) begin
            q++;
            @(negedge clk);
        end
    endtask

    // Called at the first negedge where the command is on the bus.
    task automatic run_beats(input int v, input vec_t c);
        int n, beats, st, guard;
        bit first;
        logic [15:0] a;
        n = (c.burst == 0) ? 1 : int'(c.burst);
        a = c.addr; beats = 0; st = 0; first = 1'b1; guard = 0;
        while (beats < n && guard < 200) begin
            guard++;
            if (o_rd || o_wr) begin
                chk(o_addr == a, c.wrap ? "R6" : "R5", "beat address", o_addr, a);
                if (st > 0) chk(o_addr == a, "R4", "address held under stall", o_addr, a);
                chk(o_wr == c.wr && o_rd == !c.wr, "R5", "direction", {o_rd, o_wr}, {!c.wr, c.wr});
                chk(o_bc == 3'(n), "R5", "burstcount", o_bc, n);
                if (c.wr) chk(o_wdata == data_of(v, beats), "R7", "write data", o_wdata, data_of(v, beats));
                chk(o_iss == first, "R8", "issued strobe", o_iss, first);
                chk(o_tid == 4'(tid_exp), "R9", "txn id", o_tid, tid_exp[3:0]);
                first = 1'b0;
                if (st < int'(c.stall)) begin
                    wreq = 1'b1; st++;
                end else begin
                    wreq = 1'b0; st = 0; beats++;
                    a = exp_next(a, c.wrap);
                end
            end else begin
                chk(1'b0, "R4", "transfer dropped mid-command", 0, 1);
            end
            @(negedge clk);
        end
        wreq = 1'b0;
        tid_exp++;
        chk(!(o_rd || o_wr), "R5", "no extra transfer after last", {o_rd, o_wr}, 0);
    endtask

    task automatic count_run(input logic [15:0] a, output int n);
        n = 0;
        while ((p_rd || p_wr) && p_addr == a && n < 50) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int q, n, guard;
        vec_t c, b;

        repeat (3) @(negedge clk);
        chk(!o_rd && !o_wr && !o_iss, "R1", "outputs during reset", {o_rd, o_wr, o_iss}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!o_rd && !o_wr && !o_iss, "R1", "outputs after reset", {o_rd, o_wr, o_iss}, 0);
        chk(o_tid == 0, "R1", "txn id after reset", o_tid, 0);

        // Table walk: one command at a time.
        for (int v = 0; v < NV; v++) begin
            c = VECS[v];
            if (c.wr) push_words(v, (c.burst == 0) ? 1 : int'(c.burst), 1'b0);
            push_cmd(c, 1'b0);
            count_quiet(q);
            chk(q == int'(c.init) + 1, "R2", "pre-issue quiet cycles", q, c.init + 1);
            run_beats(v, c);
            repeat (int'(c.idle) + 2) @(negedge clk);
        end

        // R3: back-to-back commands, gap between them.
        c = '{1'b0, 1'b0, 16'h0700, 3'd1, 4'd0, 4'd3, 2'd0};
        b = '{1'b0, 1'b0, 16'h0800, 3'd1, 4'd2, 4'd0, 2'd0};
        push_cmd(c, 1'b0);
        push_cmd(b, 1'b0);
        count_quiet(q);
        run_beats(0, c);
        count_quiet(q);
        chk(q == 6, "R3", "quiet cycles between commands", q, 6);
        run_beats(0, b);
        repeat (3) @(negedge clk);

        // R7: write held back until its data word exists.
        c = '{1'b1, 1'b0, 16'h0900, 3'd1, 4'd0, 4'd0, 2'd0};
        push_cmd(c, 1'b0);
        for (int k = 0; k < 5; k++) begin
            chk(!o_wr && !o_rd, "R7", "no write without data", {o_rd, o_wr}, 0);
            @(negedge clk);
        end
        wd_data = data_of(9, 0);
        wd_push = 1'b1;
        @(negedge clk);
        wd_push = 1'b0;
        run_beats(9, c);
        repeat (3) @(negedge clk);

        // R11: reset in the middle of a stalled burst.
        c = '{1'b0, 1'b0, 16'h0A00, 3'd4, 4'd0, 4'd0, 2'd0};
        push_cmd(c, 1'b0);
        count_quiet(q);
        wreq = 1'b1;
        @(negedge clk);
        chk(o_rd && o_addr == 16'h0A00, "R4", "stalled read held", o_addr, 16'h0A00);
        rst = 1'b1;
        @(negedge clk);
        chk(!o_rd && !o_wr, "R11", "bus idle after mid-command reset", {o_rd, o_wr}, 0);
        @(negedge clk);
        rst = 1'b0;
        wreq = 1'b0;
        tid_exp = 0;
        @(negedge clk);
        chk(!o_rd && !o_wr, "R11", "abandoned command not resumed", {o_rd, o_wr}, 0);
        c = '{1'b0, 1'b0, 16'h0B00, 3'd1, 4'd0, 4'd0, 2'd0};
        push_cmd(c, 1'b0);
        count_quiet(q);
        chk(o_tid == 0, "R11", "txn id restarts at zero", o_tid, 0);
        run_beats(0, c);
        repeat (3) @(negedge clk);

        // R10: fixed wait counts on the second instance, stall input held high.
        wreq = 1'b1;
        c = '{1'b1, 1'b0, 16'h0C00, 3'd2, 4'd0, 4'd0, 2'd0};
        push_words(12, 2, 1'b1);
        push_cmd(c, 1'b1);
        guard = 0;
        while (!(p_rd || p_wr) && guard < 50) begin guard++; @(negedge clk); end
        chk(p_wdata == data_of(12, 0), "R10", "first write word", p_wdata, data_of(12, 0));
        count_run(16'h0C00, n);
        chk(n == 4, "R10", "write beat 0 cycles", n, 4);
        count_run(16'h0C04, n);
        chk(n == 4, "R10", "write beat 1 cycles", n, 4);
        chk(!p_rd && !p_wr, "R10", "write command done", {p_rd, p_wr}, 0);
        c = '{1'b0, 1'b0, 16'h0D00, 3'd1, 4'd0, 4'd0, 2'd0};
        push_cmd(c, 1'b1);
        guard = 0;
        while (!(p_rd || p_wr) && guard < 50) begin guard++; @(negedge clk); end
        count_run(16'h0D00, n);
        chk(n == 3, "R10", "read beat cycles", n, 3);
        wreq = 1'b0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule